// File: doc/BRIEF.md
# I2C Master Command-Queue Engine

This block is a byte-oriented I2C bus master fed from a queue of 10-bit command words. Each word holds one byte plus two control flags: one asks for a START condition before the byte, the other asks for a STOP condition after it. Software, or another engine, pushes a whole transaction into the transmit queue. The block then drives it onto SCL and SDA through open-drain pull-down enables, with no further help. A read is queued as an address word with the direction bit set, followed by a word that gives the number of bytes to fetch. Received bytes go into a receive queue. Single-cycle event pulses report queue levels, acknowledge failures, the end of a read, loss of arbitration and the return of the bus to idle.

The engine is one state machine whose states advance on quarter-bit ticks:
- **ST_IDLE** is the waiting state. If the bus is still held, SCL stays low while the engine waits.
- **ST_START** produces a START, or a repeated START when the bus is still held.
- **ST_WBIT** shifts out eight bits, checking for arbitration loss on each one.
- **ST_WACK** samples the acknowledge from the target.
- **ST_CNT** pops the byte-count word of a read.
- **ST_RBIT** shifts in eight bits.
- **ST_RACK** drives ACK, or NACK on the last byte of the burst.
- **ST_STOP** produces a STOP.

The transitions are:
- IDLE→START on a start-flagged word.
- IDLE→WBIT on a data word while the bus is held.
- START→WBIT.
- WBIT→WACK after the eighth bit.
- WBIT→IDLE on arbitration loss.
- WACK→STOP on NACK, or on ACK with the stop flag.
- WACK→CNT after an acknowledged read address.
- WACK→IDLE otherwise.
- CNT→RBIT.
- RBIT→RACK.
- RACK→RBIT while bytes remain.
- RACK→STOP or RACK→IDLE after the last byte.
- STOP→IDLE.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, both line enables are 0, both queues are empty, `bus_busy` is 0 and `tx_occ` reads all ones.
- R2: A word with bit 8 set produces a START, then sends bits 7:0 MSB first as the address byte (bit 0: 1 = read, 0 = write).
- R3: For a write, each following word is sent as a data byte. If the word has bit 9 set, a STOP follows once the target acknowledges it, and `ev_bus_free` pulses once the bus monitor sees that STOP.
- R4: A start-flagged word that also has bit 9 set sends only the address byte, then a STOP.
- R5: After an acknowledged read address, the next word gives the byte count in bits 7:0. Each byte received is pushed into the receive queue. The master ACKs every byte except the last, which gets a NACK. A STOP follows if bit 9 of the count word was set.
- R6: A NACK on the address byte or on a written byte pulses `ev_tx_err`, discards every word still in the transmit queue, and ends with a STOP.
- R7: The completion of a read burst also pulses `ev_tx_err`.
- R8: If a start-flagged word arrives while the bus is still held (no STOP since the last byte), the engine issues a repeated START without releasing the bus. Only one STOP ends the whole sequence.
- R9: Both queues hold 16 entries. `tx_occ` and `rx_occ` report the number of entries minus one.
- R10: `ev_rx_full` pulses when the receive count rises to `rx_thresh`+1.
- R11: `ev_tx_empty` pulses when the transmit count falls to 0. `ev_tx_half` pulses when it falls from above 8 to 8 or below.
- R12: If the engine releases SDA for a 1 bit and samples 0 while SCL is high, `ev_arb_lost` pulses, both lines are released and the transmit queue is discarded.
- R13: A word without the start flag, popped while the bus is not held, is discarded with no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_push | input | 1 | Push `tx_word` into the transmit queue |
| tx_word | input | 10 | Command word: bit 9 stop, bit 8 start, bits 7:0 byte |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_occ | output | 4 | Transmit entries minus one |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_occ | output | 4 | Receive entries minus one |
| rx_thresh | input | 4 | Receive threshold, zero-based |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| bus_busy | output | 1 | A START has been seen and no STOP since |
| ev_tx_empty | output | 1 | Transmit queue became empty |
| ev_tx_half | output | 1 | Transmit queue fell to half |
| ev_tx_err | output | 1 | NACK on a sent byte, or end of a read |
| ev_arb_lost | output | 1 | Arbitration lost |
| ev_rx_full | output | 1 | Receive count reached threshold + 1 |
| ev_bus_free | output | 1 | A STOP was seen on the bus |

## Verification
A behavioural target on the bench decodes the bus, logs every byte and master acknowledge, returns a counting byte pattern on reads, and NACKs one chosen address and one chosen data value. The command patterns are:
- a plain write with a STOP;
- an address-only write;
- an address refused by the target;
- a data byte refused by the target;
- a three-byte read against a threshold of two;
- a write followed by a read joined by a repeated START;
- a ten-word burst;
- a stray data word;
- a forced low SDA.

Comparing the logged bytes, the ACK/NACK pattern and the START and STOP counts separates three outcomes: a correctly finished transaction, a transaction cut short by an error, and one that leaks queued words onto the bus. The burst and read cases pin down the zero-based occupancy readouts and the level-crossing events.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
    typedef struct packed {
        logic       stop;
        logic       start;
        logic [7:0] data;
    } cmd_word_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_WBIT, ST_WACK,
        ST_CNT, ST_RBIT, ST_RACK, ST_STOP
    } eng_state_e;
endpackage

// File: rtl/i2c_cmd_fifo.sv
module i2c_cmd_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    input  logic                       flush,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/i2c_qtr_tick.sv
module i2c_qtr_tick #(
    parameter int QTR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST) && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (tick)  cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic busy,
    output logic ev_free
);
    logic scl_p, sda_p, start_seen, stop_seen;

    assign start_seen = scl_i && scl_p && sda_p && !sda_i;
    assign stop_seen  = scl_i && scl_p && !sda_p && sda_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p   <= 1'b1;
            sda_p   <= 1'b1;
            busy    <= 1'b0;
            ev_free <= 1'b0;
        end else begin
            scl_p   <= scl_i;
            sda_p   <= sda_i;
            ev_free <= stop_seen && busy;
            if (start_seen)     busy <= 1'b1;
            else if (stop_seen) busy <= 1'b0;
        end
    end

    a_r3_free_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ev_free |-> !busy);
endmodule

// File: rtl/i2c_cmd_core.sv
module i2c_cmd_core
    import i2c_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    output logic       tick_clr,
    input  cmd_word_t  head,
    input  logic       q_empty,
    output logic       q_pop,
    output logic       q_flush,
    output logic       rx_push,
    output logic [7:0] rx_byte,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       ev_nack,
    output logic       ev_rd_done,
    output logic       ev_arb
);
    eng_state_e state_q, state_d;
    logic [1:0] qph_q, qph_d;
    logic [2:0] bit_q, bit_d;
    logic [7:0] sh_q, sh_d, left_q, left_d;
    logic       stop_q, stop_d, rd_q, rd_d, adr_q, adr_d, held_q, held_d;
    logic       rstop_q, rstop_d, nak_q, nak_d;
    logic       nack_d, rdone_d, arb_d;
    logic       smp, qend;

    assign smp      = tick && (qph_q == 2'd2);
    assign qend     = tick && (qph_q == 2'd3);
    assign tick_clr = (state_q == ST_IDLE) || (state_q == ST_CNT);
    assign rx_byte  = sh_q;

    always_comb begin
        state_d = state_q;  qph_d = qph_q;   bit_d = bit_q;  sh_d = sh_q;
        left_d  = left_q;   stop_d = stop_q; rd_d = rd_q;    adr_d = adr_q;
        held_d  = held_q;   rstop_d = rstop_q; nak_d = nak_q;
        nack_d  = 1'b0;     rdone_d = 1'b0;  arb_d = 1'b0;
        q_pop   = 1'b0;     q_flush = 1'b0;  rx_push = 1'b0;
        if (tick) qph_d = qph_q + 2'd1;
        unique case (state_q)
            ST_IDLE: begin
                qph_d = 2'd0;
                if (!q_empty) begin
                    q_pop = 1'b1;
                    if (head.start) begin
                        sh_d = head.data; stop_d = head.stop;
                        rd_d = head.data[0]; adr_d = 1'b1;
                        state_d = ST_START;
                    end else if (held_q) begin
                        sh_d = head.data; stop_d = head.stop;
                        rd_d = 1'b0; adr_d = 1'b0; bit_d = 3'd0;
                        state_d = ST_WBIT;
                    end
                end
            end
            ST_START: begin
                if (qend) begin
                    state_d = ST_WBIT; bit_d = 3'd0; held_d = 1'b1;
                end
            end
            ST_WBIT: begin
                if (smp && sh_q[7] && !sda_i) begin
                    arb_d = 1'b1; q_flush = 1'b1; held_d = 1'b0;
                    state_d = ST_IDLE;
                end else if (qend) begin
                    sh_d  = {sh_q[6:0], 1'b0};
                    bit_d = bit_q + 3'd1;
                    if (bit_q == 3'd7) state_d = ST_WACK;
                end
            end
            ST_WACK: begin
                if (smp) nak_d = sda_i;
                if (qend) begin
                    if (nak_q) begin
                        nack_d = 1'b1; q_flush = 1'b1; state_d = ST_STOP;
                    end else if (adr_q && rd_q) state_d = ST_CNT;
                    else if (stop_q)            state_d = ST_STOP;
                    else                        state_d = ST_IDLE;
                end
            end
            ST_CNT: begin
                qph_d = 2'd0;
                if (!q_empty) begin
                    q_pop = 1'b1; left_d = head.data; rstop_d = head.stop;
                    bit_d = 3'd0;
                    if (head.data == 8'd0) state_d = head.stop ? ST_STOP : ST_IDLE;
                    else                   state_d = ST_RBIT;
                end
            end
            ST_RBIT: begin
                if (smp) sh_d = {sh_q[6:0], sda_i};
                if (qend) begin
                    bit_d = bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        rx_push = 1'b1; state_d = ST_RACK;
                    end
                end
            end
            ST_RACK: begin
                if (qend) begin
                    left_d = left_q - 8'd1;
                    if (left_q == 8'd1) begin
                        rdone_d = 1'b1;
                        state_d = rstop_q ? ST_STOP : ST_IDLE;
                    end else begin
                        bit_d = 3'd0; state_d = ST_RBIT;
                    end
                end
            end
            ST_STOP: begin
                if (qend) begin
                    held_d = 1'b0; state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CNT: scl_oe = held_q;
            ST_START: begin
                scl_oe = (qph_q == 2'd0) || (qph_q == 2'd3);
                sda_oe = qph_q[1];
            end
            ST_WBIT: begin
                scl_oe = (qph_q == 2'd0) || (qph_q == 2'd3);
                sda_oe = !sh_q[7];
            end
            ST_WACK, ST_RBIT: scl_oe = (qph_q == 2'd0) || (qph_q == 2'd3);
            ST_RACK: begin
                scl_oe = (qph_q == 2'd0) || (qph_q == 2'd3);
                sda_oe = (left_q != 8'd1);
            end
            ST_STOP: begin
                scl_oe = (qph_q == 2'd0);
                sda_oe = !qph_q[1];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; qph_q <= '0; bit_q <= '0; sh_q <= '0;
            left_q <= '0; stop_q <= 1'b0; rd_q <= 1'b0; adr_q <= 1'b0;
            held_q <= 1'b0; rstop_q <= 1'b0; nak_q <= 1'b0;
            ev_nack <= 1'b0; ev_rd_done <= 1'b0; ev_arb <= 1'b0;
        end else begin
            state_q <= state_d; qph_q <= qph_d; bit_q <= bit_d; sh_q <= sh_d;
            left_q <= left_d; stop_q <= stop_d; rd_q <= rd_d; adr_q <= adr_d;
            held_q <= held_d; rstop_q <= rstop_d; nak_q <= nak_d;
            ev_nack <= nack_d; ev_rd_done <= rdone_d; ev_arb <= arb_d;
        end
    end

    a_r12_arb_releases: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb |-> (!scl_oe && !sda_oe));
    a_r8_held_keeps_scl: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WACK && qend && !nak_q && !stop_q && !(adr_q && rd_q)) |=> scl_oe);
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2c_cmd_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int QTR   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tx_push,
    input  logic [9:0]                 tx_word,
    output logic                       tx_full,
    output logic                       tx_empty,
    output logic [$clog2(DEPTH)-1:0]   tx_occ,
    input  logic                       rx_pop,
    output logic [7:0]                 rx_data,
    output logic                       rx_empty,
    output logic [$clog2(DEPTH)-1:0]   rx_occ,
    input  logic [$clog2(DEPTH)-1:0]   rx_thresh,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       scl_oe,
    output logic                       sda_oe,
    output logic                       bus_busy,
    output logic                       ev_tx_empty,
    output logic                       ev_tx_half,
    output logic                       ev_tx_err,
    output logic                       ev_arb_lost,
    output logic                       ev_rx_full,
    output logic                       ev_bus_free
);
    localparam int AW     = $clog2(DEPTH);
    localparam int HALF_I = DEPTH / 2;
    localparam logic [AW:0] HALF_CNT = HALF_I[AW:0];

    logic [9:0]  tx_head;
    logic [AW:0] tx_cnt, rx_cnt, tx_prev, rx_prev, thr_lvl;
    logic        pop_w, flush_w, rxp_w, tick_w, tclr_w, nack_w, rdone_w;
    logic [7:0]  rxb_w;
    logic        rx_full_unused;

    i2c_cmd_fifo #(.W(10), .DEPTH(DEPTH)) u_txq (
        .clk, .rst_n, .push(tx_push), .wdata(tx_word), .pop(pop_w),
        .flush(flush_w), .rdata(tx_head), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty));

    i2c_cmd_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk, .rst_n, .push(rxp_w), .wdata(rxb_w), .pop(rx_pop),
        .flush(1'b0), .rdata(rx_data), .count(rx_cnt),
        .full(rx_full_unused), .empty(rx_empty));

    i2c_qtr_tick #(.QTR(QTR)) u_tick (
        .clk, .rst_n, .clr(tclr_w), .tick(tick_w));

    i2c_bus_watch u_watch (
        .clk, .rst_n, .scl_i, .sda_i, .busy(bus_busy), .ev_free(ev_bus_free));

    i2c_cmd_core u_core (
        .clk, .rst_n, .tick(tick_w), .tick_clr(tclr_w),
        .head(cmd_word_t'(tx_head)), .q_empty(tx_empty), .q_pop(pop_w),
        .q_flush(flush_w), .rx_push(rxp_w), .rx_byte(rxb_w), .sda_i,
        .scl_oe, .sda_oe, .ev_nack(nack_w), .ev_rd_done(rdone_w),
        .ev_arb(ev_arb_lost));

    assign tx_occ    = tx_cnt[AW-1:0] - 1'b1;
    assign rx_occ    = rx_cnt[AW-1:0] - 1'b1;
    assign thr_lvl   = {1'b0, rx_thresh} + {{AW{1'b0}}, 1'b1};
    assign ev_tx_err = nack_w || rdone_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_prev <= '0;
            rx_prev <= '0;
        end else begin
            tx_prev <= tx_cnt;
            rx_prev <= rx_cnt;
        end
    end

    assign ev_tx_empty = (tx_prev != '0) && (tx_cnt == '0);
    assign ev_tx_half  = (tx_prev > HALF_CNT) && (tx_cnt <= HALF_CNT);
    assign ev_rx_full  = (rx_prev < thr_lvl) && (rx_cnt >= thr_lvl);

    a_r6_nack_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        nack_w |-> tx_empty);
    a_r10_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_full |-> (rx_cnt > {1'b0, rx_thresh}));
    a_r11_half_level: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_half |-> (tx_cnt <= HALF_CNT));
endmodule

// File: tb/i2c_cmd_master_tb_top.sv
module i2c_cmd_master_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       tx_push = 1'b0, rx_pop = 1'b0;
    logic [9:0] tx_word = '0;
    logic [3:0] rx_thresh = 4'd15;
    logic       tx_full, tx_empty, rx_empty, scl_oe, sda_oe, bus_busy;
    logic [3:0] tx_occ, rx_occ;
    logic [7:0] rx_data;
    logic       ev_tx_empty, ev_tx_half, ev_tx_err, ev_arb_lost, ev_rx_full, ev_bus_free;
    logic       slv_drv, arb_force = 1'b0;
    logic       scl_l, sda_l;

    assign scl_l = ~scl_oe;
    assign sda_l = ~(sda_oe | slv_drv | arb_force);

    i2c_cmd_master dut_i (
        .clk, .rst_n, .tx_push, .tx_word, .tx_full, .tx_empty, .tx_occ,
        .rx_pop, .rx_data, .rx_empty, .rx_occ, .rx_thresh,
        .scl_i(scl_l), .sda_i(sda_l), .scl_oe, .sda_oe, .bus_busy,
        .ev_tx_empty, .ev_tx_half, .ev_tx_err, .ev_arb_lost, .ev_rx_full, .ev_bus_free);

    int total = 0, bad = 0;
    bit finished = 1'b0;
    int n_err, n_arb, n_free, n_empty, n_half, n_rxf, n_start, n_stop;
    logic [7:0] got_q[$];
    bit         mack_q[$];

    always @(negedge clk) if (rst_n) begin
        if (ev_tx_err)   n_err++;
        if (ev_arb_lost) n_arb++;
        if (ev_bus_free) n_free++;
        if (ev_tx_empty) n_empty++;
        if (ev_tx_half)  n_half++;
        if (ev_rx_full)  n_rxf++;
    end

    // behavioural target: address 0x2A, refuses data byte 0xEE, returns 0xA0,0xA1,...
    typedef enum {S_IDLE, S_ADDR, S_ACKA, S_WR, S_ACKW, S_RD, S_MACK} slv_e;
    slv_e sst;
    logic scl_p, sda_p, srd, smack;
    logic [7:0] ssh, sbyte, rd_next;
    int sbits;

    always @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1; sda_p <= 1'b1; sst <= S_IDLE; slv_drv <= 1'b0;
            sbits <= 0; ssh <= '0; sbyte <= '0; rd_next <= 8'hA0; srd <= 1'b0; smack <= 1'b0;
        end else begin
            scl_p <= scl_l; sda_p <= sda_l;
            if (scl_l && scl_p && sda_p && !sda_l) begin
                n_start++; sst <= S_ADDR; sbits <= 0; slv_drv <= 1'b0;
            end else if (scl_l && scl_p && !sda_p && sda_l) begin
                n_stop++; sst <= S_IDLE; slv_drv <= 1'b0;
            end else if (scl_l && !scl_p) begin
                case (sst)
                    S_ADDR, S_WR: begin ssh <= {ssh[6:0], sda_l}; sbits <= sbits + 1; end
                    S_RD:   sbits <= sbits + 1;
                    S_MACK: smack <= sda_l;
                    default: ;
                endcase
            end else if (!scl_l && scl_p) begin
                case (sst)
                    S_ADDR: if (sbits == 8) begin
                        got_q.push_back(ssh);
                        if (ssh[7:1] == 7'h2A) begin
                            slv_drv <= 1'b1; srd <= ssh[0]; rd_next <= 8'hA0; sst <= S_ACKA;
                        end else sst <= S_IDLE;
                    end
                    S_ACKA: begin
                        sbits <= 0;
                        if (srd) begin
                            sbyte <= rd_next; slv_drv <= ~rd_next[7];
                            rd_next <= rd_next + 8'd1; sst <= S_RD;
                        end else begin
                            slv_drv <= 1'b0; sst <= S_WR;
                        end
                    end
                    S_WR: if (sbits == 8) begin
                        got_q.push_back(ssh);
                        slv_drv <= (ssh != 8'hEE);
                        sst <= (ssh != 8'hEE) ? S_ACKW : S_IDLE;
                    end
                    S_ACKW: begin slv_drv <= 1'b0; sst <= S_WR; sbits <= 0; end
                    S_RD: if (sbits == 8) begin
                        slv_drv <= 1'b0; sst <= S_MACK;
                    end else slv_drv <= ~sbyte[7 - sbits];
                    S_MACK: begin
                        mack_q.push_back(smack);
                        if (!smack) begin
                            sbyte <= rd_next; slv_drv <= ~rd_next[7];
                            rd_next <= rd_next + 8'd1; sst <= S_RD; sbits <= 0;
                        end else begin
                            slv_drv <= 1'b0; sst <= S_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        got_q.delete(); mack_q.delete();
        n_err = 0; n_arb = 0; n_free = 0; n_empty = 0; n_half = 0; n_rxf = 0;
        n_start = 0; n_stop = 0;
    endtask

    task automatic push(input logic [9:0] w);
        @(negedge clk); tx_push = 1'b1; tx_word = w;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic push_burst(input logic [9:0] w[$]);
        foreach (w[i]) begin
            @(negedge clk); tx_push = 1'b1; tx_word = w[i];
        end
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        int guard = 0;
        while (quiet < 200 && guard < 40000) begin
            @(negedge clk); guard++;
            if (tx_empty && !bus_busy && !scl_oe && !sda_oe) quiet++; else quiet = 0;
        end
    endtask

    task automatic pop_rx(input string req, input logic [7:0] exp);
        @(negedge clk);
        chk(req, rx_data, exp);
        rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_logs();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 line enables", {scl_oe, sda_oe}, 0);
        chk("R1 queues empty", {tx_empty, rx_empty, bus_busy}, 3'b110);
        chk("R1 tx_occ all ones", tx_occ, 4'hF);

        // R2/R3 plain write 0x54,0x11,0x22+stop
        clear_logs();
        push_burst('{10'h154, 10'h011, 10'h222});
        wait_idle();
        chk("R2 address byte", got_q.size() > 0 ? got_q[0] : 0, 8'h54);
        chk("R3 byte count", got_q.size(), 3);
        chk("R3 last data", got_q.size() == 3 ? got_q[2] : 0, 8'h22);
        chk("R3 bus free event", n_free, 1);
        chk("R3 no error", n_err, 0);
        chk("R11 tx empty event", n_empty, 1);

        // R4 address-only write
        clear_logs();
        push(10'h354);
        wait_idle();
        chk("R4 only address sent", got_q.size(), 1);
        chk("R4 stop after address", n_stop, 1);

        // R6 NACK on address: later words discarded
        clear_logs();
        push_burst('{10'h160, 10'h011, 10'h222});
        wait_idle();
        chk("R6 error on address NACK", n_err, 1);
        chk("R6 later words discarded", got_q.size(), 1);
        chk("R6 stop issued", n_stop, 1);

        // R6 NACK on data byte
        clear_logs();
        push_burst('{10'h154, 10'h0EE, 10'h233});
        wait_idle();
        chk("R6 error on data NACK", n_err, 1);
        chk("R6 byte after NACK not sent", got_q.size(), 2);
        chk("R6 queue empty", tx_empty, 1);

        // R5/R7/R9/R10 read of three bytes, threshold 2
        clear_logs();
        rx_thresh = 4'd2;
        push_burst('{10'h155, 10'h203});
        wait_idle();
        chk("R5 ack pattern", mack_q.size() == 3 ? {mack_q[0], mack_q[1], mack_q[2]} : 7, 3'b001);
        chk("R7 end of read event", n_err, 1);
        chk("R10 rx threshold event", n_rxf, 1);
        chk("R9 rx_occ zero-based", rx_occ, 2);
        pop_rx("R5 first byte", 8'hA0);
        pop_rx("R5 second byte", 8'hA1);
        pop_rx("R5 third byte", 8'hA2);
        chk("R5 rx drained", rx_empty, 1);

        // R8 write then repeated START read
        clear_logs();
        rx_thresh = 4'd15;
        push_burst('{10'h154, 10'h044, 10'h155, 10'h201});
        wait_idle();
        chk("R8 two starts", n_start, 2);
        chk("R8 single stop", n_stop, 1);
        chk("R8 one bus free", n_free, 1);
        chk("R8 read address after restart", got_q.size() == 3 ? got_q[2] : 0, 8'h55);
        chk("R5 single byte NACKed", mack_q.size() == 1 ? int'(mack_q[0]) : 7, 1);
        pop_rx("R8 read byte", 8'hA0);

        // R9/R11 ten-word burst
        clear_logs();
        push_burst('{10'h154, 10'h001, 10'h002, 10'h003, 10'h004,
                     10'h005, 10'h006, 10'h007, 10'h008, 10'h209});
        chk("R9 tx_occ zero-based", tx_occ, 8);
        wait_idle();
        chk("R11 half event", n_half, 1);
        chk("R11 empty event", n_empty, 1);
        chk("R3 burst bytes", got_q.size(), 10);

        // R13 stray data word with bus idle
        clear_logs();
        begin
            int act = 0;
            @(negedge clk); tx_push = 1'b1; tx_word = 10'h099;
            @(negedge clk); tx_push = 1'b0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (scl_oe || sda_oe || bus_busy) act++;
            end
            chk("R13 no bus activity", act, 0);
            chk("R13 word discarded", tx_empty, 1);
        end

        // R12 arbitration loss on first address bit
        clear_logs();
        push_burst('{10'h1FE, 10'h212});
        begin
            int g = 0;
            while (!bus_busy && g < 1000) begin @(negedge clk); g++; end
            arb_force = 1'b1;
            g = 0;
            while (n_arb == 0 && g < 1000) begin @(negedge clk); g++; end
            @(negedge clk);
            chk("R12 lines released", {scl_oe, sda_oe}, 0);
            chk("R12 queue discarded", tx_empty, 1);
            repeat (4) @(negedge clk);
            arb_force = 1'b0;
        end
        wait_idle();
        chk("R12 arbitration event", n_arb, 1);
        chk("R12 no byte completed", got_q.size(), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule